// File: doc/BRIEF.md
# Disk Controller Host Handshake

This block is the host-side register front end of a floppy-style disk controller. It keeps the command, execution and result phases only as four bits of the main status register. Those bits are request-for-master (RQM), data direction (DIO, set when data flows toward the host), non-DMA execution (NONDMA) and command busy (CMDBUSY). No separate phase state machine exists. Every data-port access is accepted or refused by decoding those bits alone.

The host reaches three byte registers through a two-bit address. Address 0 returns the main status on a read and takes the data-rate/power register on a write. Address 1 is the data port. Address 2 is the digital output register, which can be read and written. A back end outside this block decodes the command bytes and carries out the transfers. It strobes `execStart` with the mode, direction and length of the execution phase. It strobes `resStart` for a command that has a result phase only. It strobes `xferDone` when a DMA transfer completes. The block counts the data position, passes the byte index to the back end, and raises an interrupt that stays high until the host reads the data port in result phase.

Top module: `disk_host_handshake`

## Requirements
- R1: After reset the main status reads 0x80: RQM is bit 7, DIO bit 6, NONDMA bit 5 and CMDBUSY bit 4, and all other bits are 0. After reset `dataPos` is 0, `irq` is 0, `pwrDown` is 0 and the output register (address 2) reads 0x04.
- R2: A data-port read while RQM or DIO is clear returns 0x00 and does not advance `dataPos`.
- R3: A data-port write is refused (`wrTake` low, no advance of the position) while RQM is clear or DIO is set, and also while bit 2 of the output register (active-low reset) is 0.
- R4: After the host reads the last result byte, the block returns to command phase. CMDBUSY and DIO clear, RQM stays set (status 0x80) and `dataPos` returns to 0.
- R5: A `resStart` strobe in command phase enters result phase with length `resLen`. The status becomes 0xD0, `dataPos` becomes 0 and `irq` is raised.
- R6: When an execution phase ends, the block presents a 7-byte result. NONDMA clears, RQM, DIO and CMDBUSY are set (0xD0), `dataPos` is 0 and `irq` is raised.
- R7: Each accepted command-phase write advances `dataPos`. `multiTrack` takes bit 7 of the first command byte.
- R8: `execStart` with `execDma` set gives status 0x10, so RQM is clear for the whole transfer. An `xferDone` strobe while RQM is set changes nothing.
- R9: `execStart` with `execDma` clear sets NONDMA and CMDBUSY and raises `irq`. DIO is set when `execRead` is 1 (status 0xF0) and clear otherwise (0xB0).
- R10: In a non-DMA execution, each accepted data byte advances `dataPos`. The transfer ends (R6) on the byte that makes the position equal `execLen`. A read returns `xferByte`.
- R11: A main-status read clears `pwrDown` and forces bit 2 of the output register to 1.
- R12: A rate-register write with bit 6 set resets the phase state to the R1 values and leaves `pwrDown` at 1. An output-register write that takes bit 2 from 0 to 1 also resets the phase state and clears `pwrDown`.
- R13: Once raised, `irq` stays high until an accepted data-port read in result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 2 | Register select: 0 status/rate, 1 data, 2 output register |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, valid in the cycle of `hostRd` |
| xferByte | input | 8 | Byte supplied by the back end for data-port reads |
| execStart | input | 1 | Start of an execution phase |
| execDma | input | 1 | Execution uses DMA when 1, programmed I/O when 0 |
| execRead | input | 1 | Execution moves data toward the host |
| execLen | input | LEN_W | Byte count of a programmed-I/O execution, at least 1 |
| resStart | input | 1 | Enter result phase directly from command phase |
| resLen | input | LEN_W | Result byte count for `resStart`, at least 1 |
| xferDone | input | 1 | DMA transfer completion strobe |
| wrTake | output | 1 | The data-port write in this cycle is accepted |
| rdTake | output | 1 | The data-port read in this cycle is accepted |
| dataPos | output | LEN_W | Current data byte index |
| multiTrack | output | 1 | Latched multi-track flag |
| irq | output | 1 | Interrupt request |
| pwrDown | output | 1 | Power-down bit of the rate register |

## Verification
The bench targets the refusal cases first. These are a data read in command phase, a data write during DMA execution or result phase, and a write while the output register holds reset. A decoder that looked at only one status bit would accept these accesses and move `dataPos`. Random rounds end on the exact length boundary of programmed-I/O and result reads. An off-by-one end test would leave the status at 0xF0 or 0xD0 one byte too long, or return to command phase early. The interrupt is checked across the whole execution and its first result read, so an interrupt cleared by execution-phase reads shows up. The bench also checks the two power and reset paths. A status read that failed to clear `pwrDown`, or an output-register write that reset on the wrong edge, leaves `dataPos` or `pwrDown` wrong.

// File: rtl/dhh_pkg.sv
package dhh_pkg;
  localparam int BIT_RQM  = 7;
  localparam int BIT_DIO  = 6;
  localparam int BIT_NDMA = 5;
  localparam int BIT_BUSY = 4;
  localparam int DOR_RST_BIT = 2;
  localparam int DSR_PWR_BIT = 6;
  localparam int RES_BYTES = 7;
  localparam logic [7:0] DOR_INIT = 8'h04;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_DOR  = 2'd2;

  typedef struct packed {
    logic softRst;
    logic clrPwr;
    logic forceDorRst;
    logic wrDsr;
    logic wrDor;
    logic toCmd;
    logic toResult;
    logic useExtLen;
    logic startDma;
    logic startPio;
    logic advance;
    logic latchMulti;
    logic clrIrq;
  } hsStrobe_t;
endpackage

// File: rtl/dhh_ctrl.sv
module dhh_ctrl
  import dhh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [1:0]       hostAddr,
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic [7:0]       hostWdata,
  input  logic             xferDone,
  input  logic             execStart,
  input  logic             execDma,
  input  logic             resStart,
  input  logic             rqm,
  input  logic             dio,
  input  logic             nonDma,
  input  logic             busy,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  input  logic             dorRst,
  output hsStrobe_t        stb,
  output logic             wrTake,
  output logic             rdTake
);
  logic rdStat, wrRate, wrDorReg, rdData, wrData, lastByte;

  assign rdStat   = hostRd && hostAddr == ADDR_STAT;
  assign wrRate   = hostWr && hostAddr == ADDR_STAT;
  assign wrDorReg = hostWr && hostAddr == ADDR_DOR;
  assign rdData   = hostRd && hostAddr == ADDR_DATA;
  assign wrData   = hostWr && hostAddr == ADDR_DATA;
  assign lastByte = LEN_W'(pos + 1'b1) == len;

  always_comb begin
    stb    = '0;
    wrTake = 1'b0;
    rdTake = 1'b0;
    // register side effects
    if (rdStat) begin
      stb.clrPwr      = 1'b1;
      stb.forceDorRst = 1'b1;
    end
    if (wrRate) begin
      stb.wrDsr = 1'b1;
      if (hostWdata[DSR_PWR_BIT]) stb.softRst = 1'b1;
    end
    if (wrDorReg) begin
      stb.wrDor = 1'b1;
      if (hostWdata[DOR_RST_BIT] && !dorRst) begin
        stb.softRst = 1'b1;
        stb.clrPwr  = 1'b1;
      end
    end
    // phase events, highest priority first
    if (!stb.softRst) begin
      if (xferDone && !rqm) begin
        stb.toResult = 1'b1;
      end else if (execStart && !busy) begin
        if (execDma) stb.startDma = 1'b1;
        else         stb.startPio = 1'b1;
      end else if (resStart && !busy) begin
        stb.toResult  = 1'b1;
        stb.useExtLen = 1'b1;
      end else if (wrData && rqm && !dio && dorRst) begin
        wrTake      = 1'b1;
        stb.advance = 1'b1;
        if (nonDma) begin
          if (lastByte) stb.toResult = 1'b1;
        end else if (pos == '0) begin
          stb.latchMulti = 1'b1;
        end
      end else if (rdData && rqm && dio) begin
        rdTake      = 1'b1;
        stb.advance = 1'b1;
        if (nonDma) begin
          if (lastByte) stb.toResult = 1'b1;
        end else begin
          stb.clrIrq = 1'b1;
          if (lastByte) stb.toCmd = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dhh_datapath.sv
module dhh_datapath
  import dhh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobe_t        stb,
  input  logic [7:0]       hostWdata,
  input  logic             execRead,
  input  logic [LEN_W-1:0] execLen,
  input  logic [LEN_W-1:0] resLen,
  output logic [7:0]       msrQ,
  output logic [LEN_W-1:0] posQ,
  output logic [LEN_W-1:0] lenQ,
  output logic [7:0]       dsrQ,
  output logic [7:0]       dorQ,
  output logic             irqQ,
  output logic             multiQ
);
  localparam logic [7:0] MSR_IDLE = 8'(1 << BIT_RQM);
  localparam logic [LEN_W-1:0] RES_LEN = LEN_W'(RES_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msrQ   <= MSR_IDLE;
      posQ   <= '0;
      lenQ   <= '0;
      irqQ   <= 1'b0;
      multiQ <= 1'b0;
    end else if (stb.softRst) begin
      msrQ   <= MSR_IDLE;
      posQ   <= '0;
      lenQ   <= '0;
      irqQ   <= 1'b0;
      multiQ <= 1'b0;
    end else begin
      if (stb.toResult) begin
        msrQ[BIT_RQM]  <= 1'b1;
        msrQ[BIT_DIO]  <= 1'b1;
        msrQ[BIT_BUSY] <= 1'b1;
        msrQ[BIT_NDMA] <= 1'b0;
        lenQ <= stb.useExtLen ? resLen : RES_LEN;
        posQ <= '0;
      end else if (stb.toCmd) begin
        msrQ[BIT_BUSY] <= 1'b0;
        msrQ[BIT_DIO]  <= 1'b0;
        posQ <= '0;
      end else if (stb.startDma) begin
        msrQ[BIT_BUSY] <= 1'b1;
        msrQ[BIT_RQM]  <= 1'b0;
        posQ <= '0;
        lenQ <= execLen;
      end else if (stb.startPio) begin
        msrQ[BIT_BUSY] <= 1'b1;
        msrQ[BIT_NDMA] <= 1'b1;
        msrQ[BIT_DIO]  <= execRead;
        posQ <= '0;
        lenQ <= execLen;
      end else if (stb.advance) begin
        posQ <= posQ + 1'b1;
      end

      if (stb.toResult || stb.startPio) irqQ <= 1'b1;
      else if (stb.clrIrq)              irqQ <= 1'b0;

      if (stb.latchMulti) multiQ <= hostWdata[7];
    end
  end

  // rate and output registers survive the phase reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dsrQ <= '0;
      dorQ <= DOR_INIT;
    end else begin
      if (stb.wrDsr)       dsrQ <= hostWdata;
      else if (stb.clrPwr) dsrQ[DSR_PWR_BIT] <= 1'b0;
      if (stb.wrDor)            dorQ <= hostWdata;
      else if (stb.forceDorRst) dorQ[DOR_RST_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/disk_host_handshake.sv
module disk_host_handshake
  import dhh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       hostAddr,
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic [7:0]       hostWdata,
  output logic [7:0]       hostRdata,
  input  logic [7:0]       xferByte,
  input  logic             execStart,
  input  logic             execDma,
  input  logic             execRead,
  input  logic [LEN_W-1:0] execLen,
  input  logic             resStart,
  input  logic [LEN_W-1:0] resLen,
  input  logic             xferDone,
  output logic             wrTake,
  output logic             rdTake,
  output logic [LEN_W-1:0] dataPos,
  output logic             multiTrack,
  output logic             irq,
  output logic             pwrDown
);
  hsStrobe_t        stb;
  logic [7:0]       msrQ, dsrQ, dorQ;
  logic [LEN_W-1:0] lenQ;

  dhh_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .xferDone(xferDone), .execStart(execStart), .execDma(execDma), .resStart(resStart),
    .rqm(msrQ[BIT_RQM]), .dio(msrQ[BIT_DIO]), .nonDma(msrQ[BIT_NDMA]), .busy(msrQ[BIT_BUSY]),
    .pos(dataPos), .len(lenQ), .dorRst(dorQ[DOR_RST_BIT]),
    .stb(stb), .wrTake(wrTake), .rdTake(rdTake)
  );

  dhh_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata), .execRead(execRead),
    .execLen(execLen), .resLen(resLen), .msrQ(msrQ), .posQ(dataPos), .lenQ(lenQ),
    .dsrQ(dsrQ), .dorQ(dorQ), .irqQ(irq), .multiQ(multiTrack)
  );

  assign pwrDown = dsrQ[DSR_PWR_BIT];

  always_comb begin
    unique case (hostAddr)
      ADDR_STAT: hostRdata = msrQ;
      ADDR_DATA: hostRdata = (msrQ[BIT_RQM] && msrQ[BIT_DIO]) ? xferByte : 8'h00;
      ADDR_DOR:  hostRdata = dorQ;
      default:   hostRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dhh_checker.sv
module dhh_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       hostAddr,
  input logic             hostRd,
  input logic             hostWr,
  input logic [7:0]       hostWdata,
  input logic [7:0]       hostRdata,
  input logic             execStart,
  input logic             execDma,
  input logic             resStart,
  input logic             xferDone,
  input logic             wrTake,
  input logic             irq,
  input logic             pwrDown,
  input logic [LEN_W-1:0] dataPos,
  input logic [7:0]       msrQ,
  input logic [7:0]       dorQ
);
  a_r2_read_refused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd1 && !(msrQ[7] && msrQ[6])) |-> hostRdata == 8'h00);

  a_r3_write_refused: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd1 && (!msrQ[7] || msrQ[6] || !dorQ[2])) |-> !wrTake);

  a_r6_done_result: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !msrQ[7] && !hostWr) |=> (msrQ == 8'hD0 && irq && dataPos == '0));

  a_r8_done_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && msrQ[7] && !hostWr && !hostRd && !execStart && !resStart) |=> $stable(msrQ));

  a_r9_pio_start: assert property (@(posedge clk) disable iff (!rstN)
    (execStart && !execDma && !msrQ[4] && !hostWr) |=> (msrQ[5] && msrQ[4] && irq));

  a_r11_status_read: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd0 && !hostWr) |=> (!pwrDown && dorQ[2]));

  a_r12_rate_reset: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0 && hostWdata[6]) |=> (msrQ == 8'h80 && dataPos == '0 && pwrDown));

  a_r13_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(hostRd && hostAddr == 2'd1) && !hostWr) |=> irq);
endmodule

bind disk_host_handshake dhh_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
  .hostWdata(hostWdata), .hostRdata(hostRdata), .execStart(execStart), .execDma(execDma),
  .resStart(resStart), .xferDone(xferDone), .wrTake(wrTake), .irq(irq), .pwrDown(pwrDown),
  .dataPos(dataPos), .msrQ(msrQ), .dorQ(dorQ)
);

// File: tb/disk_host_handshake_bench.sv
module disk_host_handshake_bench;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] hostAddr = '0;
  logic hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata, xferByte = '0;
  logic execStart = 1'b0, execDma = 1'b0, execRead = 1'b0, resStart = 1'b0, xferDone = 1'b0;
  logic [LEN_W-1:0] execLen = '0, resLen = '0, dataPos;
  logic wrTake, rdTake, multiTrack, irq, pwrDown;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic lastTake;
  logic [7:0] rv;

  disk_host_handshake #(.LEN_W(LEN_W)) u_disk_host_handshake (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] msrOf(bit rqm, bit dio, bit ndma, bit busy);
    return {rqm, dio, ndma, busy, 4'b0000};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    #1 lastTake = wrTake;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata; lastTake = rdTake;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic pulseExec(bit dma, bit rd, logic [LEN_W-1:0] l);
    @(negedge clk);
    execStart = 1'b1; execDma = dma; execRead = rd; execLen = l;
    @(negedge clk);
    execStart = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic pulseRes(logic [LEN_W-1:0] l);
    @(negedge clk);
    resStart = 1'b1; resLen = l;
    @(negedge clk);
    resStart = 1'b0;
  endtask

  task automatic checkMsr(logic [7:0] exp, string req);
    logic [7:0] v;
    hostRead(2'd0, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic readResult(int n);
    logic [7:0] v;
    check(irq == 1'b1, "R13 irq held into result", irq, 1);
    for (int j = 0; j < n; j++) begin
      xferByte = 8'($urandom);
      hostRead(2'd1, v);
      check(v == xferByte, "R4 result byte", v, xferByte);
      if (j == 0) check(irq == 1'b0, "R13 irq cleared by result read", irq, 0);
      if (j < n - 1) check(dataPos == LEN_W'(j + 1), "R4 result position", dataPos, j + 1);
    end
    check(dataPos == '0, "R4 position back to 0", dataPos, 0);
    checkMsr(8'h80, "R4 back to command phase");
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stimulus
    int seedVal;
    logic [7:0] first;
    seedVal = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(dataPos == '0, "R1 position", dataPos, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(pwrDown == 1'b0, "R1 pwrDown", pwrDown, 0);
    hostRead(2'd2, rv);
    check(rv == 8'h04, "R1 output register", rv, 8'h04);
    checkMsr(8'h80, "R1 status");

    // R2 refused read in command phase
    xferByte = 8'hA5;
    hostRead(2'd1, rv);
    check(rv == 8'h00, "R2 refused read value", rv, 0);
    check(dataPos == '0, "R2 no advance", dataPos, 0);

    // R8 completion strobe ignored while RQM set
    pulseDone();
    check(irq == 1'b0, "R8 ignored done irq", irq, 0);
    checkMsr(8'h80, "R8 ignored done status");

    // random rounds
    for (int it = 0; it < 60; it++) begin
      int nCmd;
      int mode;
      int l;
      nCmd = 1 + int'($urandom % 4);
      first = 8'h00;
      for (int i = 0; i < nCmd; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if (i == 0) first = b;
        hostWrite(2'd1, b);
        check(lastTake == 1'b1, "R7 command byte accepted", lastTake, 1);
      end
      check(dataPos == LEN_W'(nCmd), "R7 command position", dataPos, nCmd);
      check(multiTrack == first[7], "R7 multi-track flag", multiTrack, first[7]);
      mode = int'($urandom % 4);
      l = 1 + int'($urandom % 8);
      if (mode == 0) begin
        pulseExec(1'b1, 1'($urandom), LEN_W'(l));
        checkMsr(msrOf(0, 0, 0, 1), "R8 DMA status");
        hostWrite(2'd1, 8'h5A);
        check(lastTake == 1'b0, "R3 write refused during DMA", lastTake, 0);
        pulseDone();
        check(irq == 1'b1, "R6 irq at transfer end", irq, 1);
        check(dataPos == '0, "R6 position zero", dataPos, 0);
        checkMsr(8'hD0, "R6 result status");
        hostWrite(2'd1, 8'h33);
        check(lastTake == 1'b0, "R3 write refused with DIO set", lastTake, 0);
        readResult(7);
      end else if (mode == 1) begin
        pulseExec(1'b0, 1'b1, LEN_W'(l));
        check(irq == 1'b1, "R9 irq at PIO start", irq, 1);
        checkMsr(msrOf(1, 1, 1, 1), "R9 PIO read status");
        for (int j = 0; j < l; j++) begin
          xferByte = 8'($urandom);
          hostRead(2'd1, rv);
          check(rv == xferByte, "R10 PIO read byte", rv, xferByte);
          if (j < l - 1) check(dataPos == LEN_W'(j + 1), "R10 PIO position", dataPos, j + 1);
        end
        checkMsr(8'hD0, "R10 PIO read end");
        readResult(7);
      end else if (mode == 2) begin
        pulseExec(1'b0, 1'b0, LEN_W'(l));
        check(irq == 1'b1, "R9 irq at PIO start", irq, 1);
        checkMsr(msrOf(1, 0, 1, 1), "R9 PIO write status");
        for (int j = 0; j < l; j++) begin
          hostWrite(2'd1, 8'($urandom));
          check(lastTake == 1'b1, "R10 PIO write accepted", lastTake, 1);
          if (j < l - 1) check(dataPos == LEN_W'(j + 1), "R10 PIO position", dataPos, j + 1);
        end
        checkMsr(8'hD0, "R10 PIO write end");
        readResult(7);
      end else begin
        l = 1 + int'($urandom % 5);
        pulseRes(LEN_W'(l));
        check(irq == 1'b1, "R5 irq at result entry", irq, 1);
        check(dataPos == '0, "R5 position zero", dataPos, 0);
        checkMsr(8'hD0, "R5 result status");
        readResult(l);
      end
    end

    // R12 rate write with power-down resets mid-command
    hostWrite(2'd1, 8'h11);
    hostWrite(2'd1, 8'h22);
    hostWrite(2'd0, 8'h40);
    check(pwrDown == 1'b1, "R12 pwrDown kept", pwrDown, 1);
    check(dataPos == '0, "R12 rate reset position", dataPos, 0);
    // R11 status read clears power-down
    checkMsr(8'h80, "R12 rate reset status");
    check(pwrDown == 1'b0, "R11 status read clears pwrDown", pwrDown, 0);

    // R3 writes ignored while output reset bit low, R11 forces it high
    hostWrite(2'd2, 8'h00);
    hostWrite(2'd1, 8'h77);
    check(lastTake == 1'b0, "R3 write refused in reset", lastTake, 0);
    check(dataPos == '0, "R3 no advance in reset", dataPos, 0);
    checkMsr(8'h80, "R11 status during reset");
    hostRead(2'd2, rv);
    check(rv[2] == 1'b1, "R11 output reset bit forced", rv, 8'h04);

    // R12 output reset bit rising resets and clears power-down
    hostWrite(2'd0, 8'h40);
    hostWrite(2'd1, 8'h81);
    hostWrite(2'd1, 8'h02);
    hostWrite(2'd2, 8'h00);
    hostWrite(2'd2, 8'h04);
    check(pwrDown == 1'b0, "R12 rising reset clears pwrDown", pwrDown, 0);
    check(dataPos == '0, "R12 rising reset position", dataPos, 0);
    check(multiTrack == 1'b0, "R12 rising reset multi", multiTrack, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule